// File: doc/BRIEF.md
# Latched-Address Byte-Lane Static RAM

This block is a single-port static RAM whose word is split into two 9-bit lanes. The address and the active-low chip select pass through a level-sensitive hold stage steered by one latch-enable input. The write data passes through a second hold stage with its own latch-enable input. While an enable is high, its stage is transparent and the inputs reach the array in the same cycle. While it is low, the stage keeps the value it last captured and ignores its inputs. A host can therefore present an address or a data word, close the stage, and then move its own bus on to the next transfer. With both enables tied high, the block acts as a plain asynchronous-style RAM.

Each lane has its own active-low write strobe, so a write may update the lower lane, the upper lane, or both. Read data leaves on an output bus with a drive-enable flag. A pad wrapper combines these into one shared three-state data bus. The array is not reset, and a location that was never written returns no defined value. The hold stages are emulated in a clocked design: each stage captures at every rising clock edge while its enable is high, and a write takes effect at the rising edge.

Top module: `latched_byte_sram`

## Requirements
- R1: While `addr_le` is 1, the address and chip select used by the array are the current `addr` and `cs_n` inputs. A read shows the addressed word in the same cycle.
- R2: While `addr_le` is 0, the array uses the address and chip select captured at the last rising edge at which `addr_le` was 1. Changes on `addr` and `cs_n` have no effect on reads or on the write location.
- R3: While `data_le` is 1, a write stores the current `dq_i`. While it is 0, a write stores the `dq_i` value captured at the last rising edge at which `data_le` was 1.
- R4: A write with `wr_lo_n`=0 and `wr_hi_n`=1 replaces bits 8:0 of the addressed word and leaves bits 17:9 unchanged.
- R5: A write with `wr_hi_n`=0 and `wr_lo_n`=1 replaces bits 17:9 of the addressed word and leaves bits 8:0 unchanged.
- R6: With both strobes at 0, the whole 18-bit word is written at the rising edge, and a later read returns it.
- R7: `dq_oe` is 1 only when the chip select in use is 0, `rd_en_n` is 0 and both write strobes are 1. `dq_o` then carries the addressed word. In every other case `dq_oe` is 0 and `dq_o` is all zeros.
- R8: While the chip select in use is 1, write strobes leave the array unchanged.
- R9: Synchronous active-low `rst_n` sets the held chip select to 1 (deselected), the held address to 0 and the held data to 0. No write takes place while `rst_n` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; hold stages capture and writes occur on the rising edge |
| rst_n | input | 1 | Synchronous active-low reset of the hold stages |
| addr | input | ADDR_W | Word address |
| cs_n | input | 1 | Chip select, active low |
| addr_le | input | 1 | Enable of the address and chip-select hold stage (1 = transparent) |
| data_le | input | 1 | Enable of the write-data hold stage (1 = transparent) |
| wr_lo_n | input | 1 | Write strobe of bits 8:0, active low |
| wr_hi_n | input | 1 | Write strobe of bits 17:9, active low |
| rd_en_n | input | 1 | Output drive request, active low |
| dq_i | input | 18 | Write data from the shared bus |
| dq_o | output | 18 | Read data towards the shared bus |
| dq_oe | output | 1 | 1 when the block drives the shared bus |

## Verification
Every cycle, the assertions check the drive rule of the output flag against the pins, check that the output is zero whenever it is not driven, and check that the block comes out of reset deselected. They also check that a held address with no write in between gives a steady output. Whether a byte strobe touched only its own lane, whether the held data rather than the live bus was stored, and whether a write went to the held address can only be shown by the bench's write-then-read scenarios. The same applies to showing that a deselected write or a write during reset left a known word intact.

// File: rtl/sram_pkg.sv
// Shared definitions for the latched-address byte-lane RAM.
// Assumes: nothing beyond IEEE 1800-2017 packages.
package sram_pkg;

    // Bus drive state chosen by the output controller.
    typedef enum logic {
        BUS_FLOAT = 1'b0,
        BUS_DRIVE = 1'b1
    } bus_state_e;

    // Index of each byte lane inside the data word.
    localparam int LANE_LO = 0;
    localparam int LANE_HI = 1;

endpackage

// File: rtl/sram_hold_stage.sv
// Level-controlled hold stage emulated on a clock.
// While en is high the output follows d in the same cycle, and the hold
// register captures d at every rising edge. While en is low the output
// is the held value. Assumes: a synchronous active-low reset loads RST_VAL.
module sram_hold_stage #(
    parameter int         W       = 8,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] held;

    // Capture the input on every edge at which the stage is transparent.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held <= RST_VAL;
        end else if (en) begin
            held <= d;
        end
    end

    // Select the live input while transparent, the held copy otherwise.
    always_comb begin
        q = en ? d : held;
    end

endmodule

// File: rtl/sram_lane_array.sv
// Storage split into independently writable lanes.
// Each lane is its own array with its own write enable. The read is
// combinational from the address. Assumes: no reset of contents, and
// callers gate wr_en with chip select and reset.
module sram_lane_array #(
    parameter int ADDR_W = 10,
    parameter int LANE_W = 9,
    parameter int LANES  = 2
) (
    input  logic                    clk,
    input  logic [LANES-1:0]        wr_en,
    input  logic [ADDR_W-1:0]       addr,
    input  logic [LANES*LANE_W-1:0] wdata,
    output logic [LANES*LANE_W-1:0] rdata
);

    localparam int DEPTH = 1 << ADDR_W;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] cells [DEPTH];

        // Store this lane's slice when its strobe is active.
        always_ff @(posedge clk) begin
            if (wr_en[g]) begin
                cells[addr] <= wdata[g*LANE_W +: LANE_W];
            end
        end

        // Present this lane's slice of the addressed word.
        always_comb begin
            rdata[g*LANE_W +: LANE_W] = cells[addr];
        end
    end

endmodule

// File: rtl/sram_bus_ctl.sv
// Output drive control for the shared data bus.
// Drives only on a selected read (select low, drive request low, no
// write strobe). Otherwise it floats and returns zeros. Assumes: the
// select input is the held copy.
module sram_bus_ctl #(
    parameter int W = 18
) (
    input  logic         sel_n,
    input  logic         rd_en_n,
    input  logic         any_wr,
    input  logic [W-1:0] rdata,
    output logic [W-1:0] dq_o,
    output logic         dq_oe
);

    import sram_pkg::*;

    bus_state_e state;

    // Decide whether this cycle is a bus read.
    always_comb begin
        if (!sel_n && !rd_en_n && !any_wr) begin
            state = BUS_DRIVE;
        end else begin
            state = BUS_FLOAT;
        end
    end

    // Gate the read data with the drive decision.
    always_comb begin
        dq_oe = (state == BUS_DRIVE);
        dq_o  = (state == BUS_DRIVE) ? rdata : '0;
    end

endmodule

// File: rtl/latched_byte_sram.sv
// Top of the latched-address byte-lane RAM.
// One hold stage covers address and chip select, a second covers write
// data. Two lane strobes write the lower and upper halves. Assumes:
// synchronous active-low reset of the hold stages only. ADDR_W of 16
// gives the full 64K-word part.
module latched_byte_sram #(
    parameter int ADDR_W = 10,
    parameter int LANE_W = 9
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ADDR_W-1:0]   addr,
    input  logic                cs_n,
    input  logic                addr_le,
    input  logic                data_le,
    input  logic                wr_lo_n,
    input  logic                wr_hi_n,
    input  logic                rd_en_n,
    input  logic [2*LANE_W-1:0] dq_i,
    output logic [2*LANE_W-1:0] dq_o,
    output logic                dq_oe
);

    import sram_pkg::*;

    localparam int LANES  = 2;
    localparam int DATA_W = LANES * LANE_W;
    localparam int AC_W   = ADDR_W + 1;

    logic [AC_W-1:0]   ac_live;
    logic [AC_W-1:0]   ac_use;
    logic [ADDR_W-1:0] addr_use;
    logic              cs_use_n;
    logic [DATA_W-1:0] data_use;
    logic [DATA_W-1:0] rdata;
    logic [LANES-1:0]  strobe;
    logic [LANES-1:0]  wr_en;
    logic              any_wr;

    // Bundle chip select with the address; reset deselects.
    always_comb begin
        ac_live = {cs_n, addr};
    end

    sram_hold_stage #(
        .W       (AC_W),
        .RST_VAL ({1'b1, {ADDR_W{1'b0}}})
    ) u_addr_hold (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (addr_le),
        .d     (ac_live),
        .q     (ac_use)
    );

    sram_hold_stage #(
        .W       (DATA_W),
        .RST_VAL ('0)
    ) u_data_hold (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (data_le),
        .d     (dq_i),
        .q     (data_use)
    );

    // Split the held bundle back into select and address.
    always_comb begin
        cs_use_n = ac_use[AC_W-1];
        addr_use = ac_use[ADDR_W-1:0];
    end

    // Map the lane strobes to active-high lane requests.
    always_comb begin
        strobe          = '0;
        strobe[LANE_LO] = !wr_lo_n;
        strobe[LANE_HI] = !wr_hi_n;
        any_wr          = |strobe;
    end

    // Qualify lane writes with the held select and with reset.
    always_comb begin
        wr_en = (rst_n && !cs_use_n) ? strobe : '0;
    end

    sram_lane_array #(
        .ADDR_W (ADDR_W),
        .LANE_W (LANE_W),
        .LANES  (LANES)
    ) u_array (
        .clk   (clk),
        .wr_en (wr_en),
        .addr  (addr_use),
        .wdata (data_use),
        .rdata (rdata)
    );

    sram_bus_ctl #(
        .W (DATA_W)
    ) u_bus (
        .sel_n   (cs_use_n),
        .rd_en_n (rd_en_n),
        .any_wr  (any_wr),
        .rdata   (rdata),
        .dq_o    (dq_o),
        .dq_oe   (dq_oe)
    );

endmodule

// File: rtl/latched_byte_sram_chk.sv
// Property checker for latched_byte_sram, attached by bind.
// Assumes: the reset is held low over the first rising edge.
module latched_byte_sram_chk #(
    parameter int DATA_W = 18
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cs_n,
    input logic              addr_le,
    input logic              wr_lo_n,
    input logic              wr_hi_n,
    input logic              rd_en_n,
    input logic [DATA_W-1:0] dq_o,
    input logic              dq_oe
);

    logic started;

    // Mark the cycles after the first one out of reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            started <= 1'b0;
        end else begin
            started <= 1'b1;
        end
    end

    // R7: a transparent, selected read with no strobe must drive.
    a_r7_drive_on_read: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_le && !cs_n && !rd_en_n && wr_lo_n && wr_hi_n) |-> dq_oe);

    // R7: any strobe or a missing drive request keeps the bus floating.
    a_r7_float_otherwise: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_lo_n || !wr_hi_n || rd_en_n) |-> !dq_oe);

    // R7: the undriven output is all zeros.
    a_r7_zero_when_float: assert property (@(posedge clk) disable iff (!rst_n)
        !dq_oe |-> (dq_o == '0));

    // R9: right after reset with the stage closed, the block is deselected.
    a_r9_deselect_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
        (!started && !addr_le) |-> !dq_oe);

    // R2: a held address with no write gives a steady output.
    a_r2_hold_steady: assert property (@(posedge clk) disable iff (!rst_n)
        (started && !addr_le && $past(!addr_le) && wr_lo_n && wr_hi_n &&
         $past(wr_lo_n && wr_hi_n) && dq_oe && $past(dq_oe)) |-> $stable(dq_o));

endmodule

bind latched_byte_sram latched_byte_sram_chk #(
    .DATA_W (2*LANE_W)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .cs_n    (cs_n),
    .addr_le (addr_le),
    .wr_lo_n (wr_lo_n),
    .wr_hi_n (wr_hi_n),
    .rd_en_n (rd_en_n),
    .dq_o    (dq_o),
    .dq_oe   (dq_oe)
);

// File: tb/test_latched_byte_sram.sv
module test_latched_byte_sram;

    localparam int AW = 6;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [AW-1:0] addr;
    logic          cs_n, addr_le, data_le, wr_lo_n, wr_hi_n, rd_en_n;
    logic [17:0]   dq_i;
    logic [17:0]   dq_o;
    logic          dq_oe;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    latched_byte_sram #(.ADDR_W(AW), .LANE_W(9)) i_latched_byte_sram (
        .clk(clk), .rst_n(rst_n), .addr(addr), .cs_n(cs_n),
        .addr_le(addr_le), .data_le(data_le), .wr_lo_n(wr_lo_n),
        .wr_hi_n(wr_hi_n), .rd_en_n(rd_en_n), .dq_i(dq_i),
        .dq_o(dq_o), .dq_oe(dq_oe)
    );

    typedef struct packed {
        logic          ale;
        logic          dle;
        logic [AW-1:0] a;
        logic          cs;
        logic          wl;
        logic          wh;
        logic          rd;
        logic [17:0]   din;
        logic          chk;
        logic          eoe;
        logic [17:0]   eq;
        logic [7:0]    req;
    } vec_t;

    localparam int NV = 22;
    localparam vec_t VECS [NV] = '{
        '{1,1,6'd5, 0,0,0,1,18'h2AB55,1,0,18'h00000,6}, // R6 full write
        '{1,1,6'd5, 0,1,1,0,18'h00000,1,1,18'h2AB55,6}, // R6 read back
        '{1,1,6'd5, 0,0,1,1,18'h3FFFF,1,0,18'h00000,4}, // R4 lower only
        '{1,1,6'd5, 0,1,1,0,18'h00000,1,1,18'h2ABFF,4}, // R4 upper kept
        '{1,1,6'd5, 0,1,0,1,18'h00000,1,0,18'h00000,5}, // R5 upper only
        '{1,1,6'd5, 0,1,1,0,18'h00000,1,1,18'h001FF,5}, // R5 lower kept
        '{1,1,6'd9, 0,0,0,1,18'h12345,1,0,18'h00000,7}, // R7 float while writing
        '{1,1,6'd9, 0,1,1,0,18'h00000,1,1,18'h12345,1}, // R1 live address
        '{1,1,6'd9, 1,0,0,1,18'h00000,1,0,18'h00000,8}, // R8 deselected write
        '{1,1,6'd9, 0,1,1,0,18'h00000,1,1,18'h12345,8}, // R8 word intact
        '{1,1,6'd9, 0,1,1,1,18'h00000,1,0,18'h00000,7}, // R7 no drive request
        '{1,1,6'd9, 1,1,1,0,18'h00000,1,0,18'h00000,7}, // R7 deselected read
        '{1,1,6'd9, 0,1,1,0,18'h00000,1,1,18'h12345,2}, // R2 capture addr 9
        '{0,1,6'd5, 0,1,1,0,18'h00000,1,1,18'h12345,2}, // R2 address held
        '{0,1,6'd5, 1,1,1,0,18'h00000,1,1,18'h12345,2}, // R2 select held
        '{1,1,6'd5, 0,1,1,0,18'h00000,1,1,18'h001FF,1}, // R1 reopen
        '{1,1,6'd7, 0,1,1,1,18'h0F0F0,0,0,18'h00000,3}, // R3 capture data
        '{1,0,6'd7, 0,0,0,1,18'h3FFFF,1,0,18'h00000,3}, // R3 write held data
        '{1,1,6'd7, 0,1,1,0,18'h00000,1,1,18'h0F0F0,3}, // R3 held data stored
        '{1,1,6'd11,0,1,1,1,18'h00000,0,0,18'h00000,2}, // R2 capture addr 11
        '{0,1,6'd12,0,0,0,1,18'h01111,1,0,18'h00000,2}, // R2 write to held addr
        '{1,1,6'd11,0,1,1,0,18'h00000,1,1,18'h01111,2}  // R2 landed at 11
    };

    task automatic check_out(input string tag, input logic eoe, input logic [17:0] eq);
        logic [17:0] want;
        want = eoe ? eq : 18'h0;
        checks++;
        if (dq_oe !== eoe || dq_o !== want) begin
            errors++;
            $display("FAIL %s: oe=%0b q=%05h expected oe=%0b q=%05h", tag, dq_oe, dq_o, eoe, want);
        end
    endtask

    task automatic drive(input logic ale, input logic dle, input logic [AW-1:0] a,
                         input logic cs, input logic wl, input logic wh,
                         input logic rd, input logic [17:0] din);
        @(negedge clk);
        addr_le = ale; data_le = dle; addr = a; cs_n = cs;
        wr_lo_n = wl; wr_hi_n = wh; rd_en_n = rd; dq_i = din;
        #1;
    endtask

    // Watchdog: a hung run counts as a failure.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 5000 && !done) begin
            done = 1'b1;
            errors++;
            checks++;
            $display("FAIL watchdog: cycles=%0d expected below 5000", cycles);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; addr = '0; cs_n = 1'b0; addr_le = 1'b0; data_le = 1'b0;
        wr_lo_n = 1'b1; wr_hi_n = 1'b1; rd_en_n = 1'b0; dq_i = '0;
        repeat (2) @(posedge clk);
        drive(0, 0, 6'd0, 0, 1, 1, 0, 18'h0);
        rst_n = 1'b1;
        #1;
        // R9: held select deselected after reset, stages closed
        check_out("R9 reset deselect", 1'b0, 18'h0);

        for (int i = 0; i < NV; i++) begin
            drive(VECS[i].ale, VECS[i].dle, VECS[i].a, VECS[i].cs,
                  VECS[i].wl, VECS[i].wh, VECS[i].rd, VECS[i].din);
            if (VECS[i].chk)
                check_out($sformatf("R%0d vector %0d", VECS[i].req, i), VECS[i].eoe, VECS[i].eq);
        end

        // R1: address change within a transparent cycle shows at once
        drive(1, 1, 6'd9, 0, 1, 1, 0, 18'h0);
        check_out("R1 same-cycle address", 1'b1, 18'h12345);

        // R9: a write under reset leaves a known word intact
        drive(1, 1, 6'd3, 0, 0, 0, 1, 18'h0AAAA);
        drive(1, 1, 6'd3, 0, 0, 0, 1, 18'h15555);
        rst_n = 1'b0;
        @(posedge clk);
        drive(1, 1, 6'd3, 0, 1, 1, 0, 18'h0);
        rst_n = 1'b1;
        #1;
        check_out("R9 no write in reset", 1'b1, 18'h0AAAA);

        // R9: reset cleared the held address and data; closed stages use them
        drive(1, 1, 6'd0, 0, 0, 0, 1, 18'h2DEAD);
        drive(1, 1, 6'd3, 0, 1, 1, 0, 18'h0);
        rst_n = 1'b0;
        @(posedge clk);
        drive(0, 0, 6'd3, 0, 1, 1, 0, 18'h0);
        rst_n = 1'b1;
        #1;
        check_out("R9 deselected after second reset", 1'b0, 18'h0);
        drive(1, 1, 6'd0, 0, 1, 1, 0, 18'h0);
        check_out("R9 word at address 0", 1'b1, 18'h2DEAD);

        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule